// File: doc/BRIEF.md
# CRC-32 Multi-Cycle Instruction Unit

This block is a coprocessor that sits beside a processor pipeline and accumulates a CRC-32 over a stream of 32-bit words. The processor issues an operation by pulsing `start` for one clock. At the same time it presents a 3-bit operation code on `n` and an operand word on `dataa`, and it keeps both steady until the block answers with a one-cycle `done`. The value on `result` is valid in that same cycle.

Three operations are defined. The first seeds the running remainder. The second folds one word into the remainder over several clocks, eight bits per clock, through a parallel network of XOR and shift stages. The third hands back the finished checksum. The other codes answer at once with zero. A low `clk_en` freezes every register, so the processor can stall the block at any point of an operation.

Top module: `crc32_cop`

## Requirements
- R1: A synchronous active-high `reset` drives `done` and `result` to 0 and sets the running remainder to 0xFFFFFFFF. A checksum read issued right after reset therefore returns 0x00000000. Reset acts whatever the value of `clk_en`.
- R2: Code `n`=0 sets the running remainder to 0xFFFFFFFF. `done` rises in the cycle after the enabled edge that accepts `start`, with `result` equal to 0.
- R3: Code `n`=1 folds `dataa` into the remainder using the reflected form of polynomial 0x04C11DB7 (0xEDB88320). The word is taken as four bytes, least significant byte first, and each byte is taken least significant bit first. `done` appears after the fourth enabled edge, counting the accepting edge as the first. `result` then carries the updated remainder without the final inversion.
- R4: Code `n`=2 returns the remainder XOR 0xFFFFFFFF. Like code 0, it answers in the cycle after the accepting edge, and it leaves the remainder unchanged, so two reads in a row return the same value.
- R5: Codes `n`=3 through 7 answer in the cycle after the accepting edge with `result` equal to 0, and they leave the remainder unchanged.
- R6: While `clk_en` is low, no register changes: `done`, `result` and the remainder hold, and stalled cycles do not count toward the fold latency.
- R7: `done` is high for exactly one enabled cycle per accepted operation, and it is never raised without a preceding `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| reset | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock qualifier; low stalls all state |
| start | input | 1 | One-cycle operation request |
| n | input | 3 | Operation code |
| dataa | input | 32 | Operand word, stable until done |
| result | output | 32 | Operation result, valid while done is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
Several properties are checked on every cycle. `done` and `result` must hold while `clk_en` is low. `done` must never appear without an outstanding request, and it must drop after an enabled cycle. A fold must finish exactly three enabled edges after it is accepted, and the seed and spare codes must answer with zero. Only the bench scenarios can show the arithmetic itself: the remainder values over many word sequences, the fact that reads and spare codes leave the remainder untouched, and that reset during a fold restores the seed value. They also show that random stalls do not change any checksum.

// File: rtl/crc32_cop_pkg.sv
package crc32_cop_pkg;
  // operation codes carried on the selector input
  typedef enum logic [2:0] {
    OP_SEED  = 3'd0,
    OP_FOLD  = 3'd1,
    OP_FETCH = 3'd2
  } crc_op_e;
endpackage

// File: rtl/crc32_cop_lane.sv
// One lane of reflected CRC update: LANE bits folded through a chain of
// XOR/shift stages in a single combinational step.
module crc32_cop_lane #(
  parameter int WIDTH = 32,
  parameter int LANE  = 8
) (
  input  logic [WIDTH-1:0] rpoly,
  input  logic [WIDTH-1:0] crc_in,
  input  logic [LANE-1:0]  bits_in,
  output logic [WIDTH-1:0] crc_out
);
  logic [WIDTH-1:0] stage [LANE+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < LANE; i++) begin : g_stage
    logic fb;
    assign fb           = stage[i][0] ^ bits_in[i];
    assign stage[i+1]   = (stage[i] >> 1) ^ (fb ? rpoly : '0);
  end

  assign crc_out = stage[LANE];
endmodule

// File: rtl/crc32_cop_seq.sv
// Beat sequencer for the fold operation: counts enabled edges and
// flags the last lane of the operand word.
module crc32_cop_seq #(
  parameter int BEATS = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             clk_en,
  input  logic             fold_req,
  output logic             busy,
  output logic [CNT_W-1:0] beat,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (reset) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clk_en) begin
      if (busy_q) begin
        if (cnt_q == LAST_BEAT) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (fold_req && (BEATS > 1)) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign beat = busy_q ? cnt_q : '0;
  assign last = busy_q ? (cnt_q == LAST_BEAT) : (BEATS == 1);
endmodule

// File: rtl/crc32_cop.sv
module crc32_cop
  import crc32_cop_pkg::*;
#(
  parameter int              WIDTH  = 32,
  parameter int              LANE   = 8,
  parameter int              OP_W   = 3,
  parameter logic [WIDTH-1:0] POLY   = 32'h04C11DB7,
  parameter logic [WIDTH-1:0] SEED   = 32'hFFFFFFFF,
  parameter logic [WIDTH-1:0] XOROUT = 32'hFFFFFFFF
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             clk_en,
  input  logic             start,
  input  logic [OP_W-1:0]  n,
  input  logic [WIDTH-1:0] dataa,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam int BEATS = WIDTH / LANE;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [WIDTH-1:0] rpoly;
  logic [WIDTH-1:0] crc_q, lane_out;
  logic [WIDTH-1:0] result_q;
  logic             done_q;
  logic             busy, last, accept, is_fold, fold_step;
  logic [CNT_W-1:0] beat;
  logic [LANE-1:0]  lane_bits;

  // reflected polynomial: bit i takes polynomial bit WIDTH-1-i
  for (genvar i = 0; i < WIDTH; i++) begin : g_reflect
    assign rpoly[i] = POLY[WIDTH-1-i];
  end

  assign accept    = start && !busy;
  assign is_fold   = (n == OP_W'(OP_FOLD));
  assign fold_step = busy || (accept && is_fold);
  assign lane_bits = dataa[int'(beat)*LANE +: LANE];

  crc32_cop_seq #(.BEATS(BEATS), .CNT_W(CNT_W)) seq_i (
    .clk      (clk),
    .reset    (reset),
    .clk_en   (clk_en),
    .fold_req (accept && is_fold),
    .busy     (busy),
    .beat     (beat),
    .last     (last)
  );

  crc32_cop_lane #(.WIDTH(WIDTH), .LANE(LANE)) lane_i (
    .rpoly   (rpoly),
    .crc_in  (crc_q),
    .bits_in (lane_bits),
    .crc_out (lane_out)
  );

  always_ff @(posedge clk) begin
    if (reset) begin
      crc_q    <= SEED;
      result_q <= '0;
      done_q   <= 1'b0;
    end else if (clk_en) begin
      done_q <= 1'b0;
      if (fold_step) begin
        crc_q <= lane_out;
        if (last) begin
          done_q   <= 1'b1;
          result_q <= lane_out;
        end
      end else if (accept) begin
        done_q <= 1'b1;
        if (n == OP_W'(OP_SEED)) begin
          crc_q    <= SEED;
          result_q <= '0;
        end else if (n == OP_W'(OP_FETCH)) begin
          result_q <= crc_q ^ XOROUT;
        end else begin
          result_q <= '0;
        end
      end
    end
  end

  assign result = result_q;
  assign done   = done_q;
endmodule

// File: rtl/crc32_cop_chk.sv
module crc32_cop_chk #(
  parameter int WIDTH = 32,
  parameter int LANE  = 8,
  parameter int OP_W  = 3
) (
  input logic             clk,
  input logic             reset,
  input logic             clk_en,
  input logic             start,
  input logic [OP_W-1:0]  n,
  input logic [WIDTH-1:0] result,
  input logic             done
);
  localparam int BEATS = WIDTH / LANE;

  logic            pend_q;
  logic [OP_W-1:0] op_q;
  logic [7:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (reset) begin
      pend_q <= 1'b0;
      op_q   <= '0;
      cnt_q  <= '0;
    end else if (clk_en) begin
      if (start && (!pend_q || done)) begin
        pend_q <= 1'b1;
        op_q   <= n;
        cnt_q  <= '0;
      end else if (done) begin
        pend_q <= 1'b0;
      end else if (pend_q && cnt_q != 8'hFF) begin
        cnt_q <= cnt_q + 8'd1;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (reset)
    !clk_en |=> ($stable(done) && $stable(result)));                     // R6
  AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (reset)
    done |-> pend_q);                                                     // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (reset)
    (clk_en && done && !start) |=> !done);                                // R7
  AST_FOLD_LATENCY: assert property (@(posedge clk) disable iff (reset)
    (done && op_q == OP_W'(1)) |-> (int'(cnt_q) == BEATS - 1));            // R3
  AST_QUICK_LATENCY: assert property (@(posedge clk) disable iff (reset)
    (done && op_q != OP_W'(1)) |-> (cnt_q == 8'd0));                      // R4
  AST_SEED_ZERO: assert property (@(posedge clk) disable iff (reset)
    (done && op_q == OP_W'(0)) |-> (result == '0));                       // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (reset)
    (done && op_q >= OP_W'(3)) |-> (result == '0));                       // R5
endmodule

bind crc32_cop crc32_cop_chk #(.WIDTH(WIDTH), .LANE(LANE), .OP_W(OP_W)) chk_i (
  .clk    (clk),
  .reset  (reset),
  .clk_en (clk_en),
  .start  (start),
  .n      (n),
  .result (result),
  .done   (done)
);

// File: tb/crc32_cop_tb_top.sv
`timescale 1ns/1ps
module crc32_cop_tb_top;
  logic        clk = 1'b0;
  logic        reset = 1'b1;
  logic        clk_en = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  n = '0;
  logic [31:0] dataa = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  crc32_cop dut_i (
    .clk(clk), .reset(reset), .clk_en(clk_en), .start(start),
    .n(n), .dataa(dataa), .result(result), .done(done)
  );

  // stall pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    clk_en <= stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // reference: bitwise reflected CRC over a whole word, LSB first
  function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 32; b++) begin
      r = r ^ {31'd0, d[b]};
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  logic [31:0] m_crc, m_res, m_pend;
  logic        m_done;
  int          m_left;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (reset) begin
      m_crc = 32'hFFFFFFFF; m_res = '0; m_done = 1'b0; m_left = 0;
    end else if (clk_en) begin
      m_done = 1'b0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_done = 1'b1; m_res = m_pend; end
      end else if (start) begin
        m_tag = cur_tag;
        case (n)
          3'd0: begin m_crc = 32'hFFFFFFFF; m_done = 1'b1; m_res = '0; end
          3'd1: begin m_crc = ref_fold(m_crc, dataa); m_pend = m_crc; m_left = 3; end
          3'd2: begin m_done = 1'b1; m_res = m_crc ^ 32'hFFFFFFFF; end
          default: begin m_done = 1'b1; m_res = '0; end
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!reset && !finished) begin
      check(done === m_done, m_done ? m_tag : "R7", {31'd0, done}, {31'd0, m_done});
      if (m_done) check(result === m_res, m_tag, result, m_res);
    end
  end

  task automatic do_op(input logic [2:0] op, input logic [31:0] w, input string tag);
    @(negedge clk);
    start = 1'b1; n = op; dataa = w; cur_tag = tag;
    forever begin @(posedge clk); if (clk_en) break; end
    @(negedge clk);
    start = 1'b0;
    forever begin @(posedge clk); if (done && clk_en) break; end
  endtask

  task automatic word_run(input int count, input logic [31:0] s, input string tag);
    logic [31:0] w = s;
    do_op(3'd0, 32'h0, "R2");
    for (int k = 0; k < count; k++) begin
      do_op(3'd1, w, tag);
      w = {w[30:0], w[31] ^ w[21] ^ w[1] ^ w[0]} ^ 32'h9E3779B9;
    end
    do_op(3'd2, 32'h0, "R4");
    do_op(3'd2, 32'h0, "R4");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(done === 1'b0, "R1", {31'd0, done}, 32'd0);
    check(result === 32'd0, "R1", result, 32'd0);
    reset = 1'b0;
    do_op(3'd2, 32'h0, "R1");              // fresh remainder reads 0
    // idle stretch: no done without start
    repeat (20) @(negedge clk);
    do_op(3'd1, 32'h00000000, "R3");
    do_op(3'd2, 32'h0, "R4");
    do_op(3'd1, 32'hFFFFFFFF, "R3");
    do_op(3'd1, 32'h12345678, "R3");
    do_op(3'd2, 32'h0, "R4");
    for (int c = 3; c < 8; c++) begin
      do_op(3'(c), 32'hDEADBEEF, "R5");
      do_op(3'd2, 32'h0, "R5");            // remainder unchanged
    end
    word_run(12, 32'hA5A5A5A5, "R3");
    stall_mode = 1;
    word_run(16, 32'h0BADF00D, "R6");
    do_op(3'd6, 32'h1, "R6");
    do_op(3'd2, 32'h0, "R6");
    stall_mode = 0;
    // reset in the middle of a fold restores the seed value
    @(negedge clk); start = 1'b1; n = 3'd1; dataa = 32'hCAFEF00D;
    @(negedge clk); start = 1'b0;
    reset = 1'b1;
    repeat (2) @(negedge clk);
    check(done === 1'b0, "R1", {31'd0, done}, 32'd0);
    reset = 1'b0;
    do_op(3'd2, 32'h0, "R1");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule